// File: doc/BRIEF.md
# Multi-Mode Buffered Serial Transmitter

This block sends bytes out on one serial line. Software writes a byte into a one-byte holding register. The byte then moves into a shift register, which drives the line one bit per baud tick. Because of the holding register, the next byte can be written while the current frame is still on the line. Back-to-back frames therefore leave no idle gap between them.

Four frame layouts are selected by a 2-bit mode input:

- Two asynchronous layouts. One carries an optional even or odd parity bit. The other carries an address/data marker bit.
- A plain asynchronous 8N1 layout.
- A synchronous layout that sends only the eight data bits. A framing control can add start and stop bits to this layout.

A "holding register empty" flag shows when the next byte may be written. This flag can only be read. An interrupt output follows the flag, gated by an enable input. A busy output shows when the line has really gone idle.

Top module: `multimode_tx`

## Requirements
- R1: After reset `holdEmpty`=1, `txBusy`=0, `txLine`=1, and `txIrq`=0 while `irqEn`=0.
- R2: `holdEmpty` goes to 1 on the baud tick that moves the pending byte into the shift register, while that frame is still in progress (`txBusy`=1).
- R3: Writing a byte (`dataWr`=1) clears `holdEmpty` on the next clock. Nothing else clears it, and a baud tick with no pending byte starts no frame.
- R4: `txIrq` is 1 exactly when `holdEmpty`=1 and `irqEn`=1.
- R5: When `txMode`=0, a frame is a start bit (0), then data bits least significant first, then a parity bit only if `parityEn`=1, then a stop bit (1). When `parityOdd`=0 the parity makes the count of ones across data and parity even; when `parityOdd`=1 it makes that count odd.
- R6: When `txMode`=1, a frame is start, eight data bits, then the value of `addrFlag` in the parity position, then stop. `parityEn` has no effect in this mode.
- R7: When `txMode`=2 and `syncFramed`=0, only the eight data bits are sent, with no start, parity or stop bits. When `syncFramed`=1, the frame is laid out as in R5.
- R8: When `txMode`=3, a frame is start, eight data bits, then stop. No parity bit is sent whatever `parityEn` is.
- R9: Each bit is held for one baud-tick period. A frame starts on the first tick at which a byte is pending and the line is idle. A byte that is pending when the last bit period ends follows with its first bit at once, with no gap.
- R10: Writing while a byte is already pending replaces the pending byte and leaves the frame in flight unchanged.
- R11: `txBusy` is 1 from the tick that starts a frame until the tick that ends its last bit period. While `txBusy`=0, `txLine`=1.
- R12: The configuration inputs are sampled at the tick that loads a frame, and that frame keeps this configuration until it ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| baudTick | input | 1 | One-cycle pulse for each bit period |
| dataWr | input | 1 | Strobe that writes `dataIn` into the holding register |
| dataIn | input | 8 | Byte to send |
| txMode | input | 2 | Frame layout: 0 async with optional parity, 1 async with address bit, 2 synchronous, 3 async 8N1 |
| parityEn | input | 1 | Adds a parity bit (modes 0 and 2 with framing) |
| parityOdd | input | 1 | 1 selects odd parity, 0 selects even parity |
| addrFlag | input | 1 | Value of the address/data marker bit in mode 1 |
| syncFramed | input | 1 | Adds start and stop bits in mode 2 |
| irqEn | input | 1 | Interrupt enable |
| txLine | output | 1 | Serial output, idles high |
| holdEmpty | output | 1 | Holding register empty flag, read-only |
| txBusy | output | 1 | A frame is being shifted out |
| txIrq | output | 1 | Level interrupt, active while the flag is set and interrupts are enabled |

## Verification
A write clears `holdEmpty` one clock after the write strobe. A baud tick changes `txLine`, `txBusy` and `holdEmpty` one clock after the tick. `txIrq` follows `holdEmpty` in the same cycle.

The bench drives every strobe for exactly one cycle on a falling edge. It samples at the next falling edge, which comes after the single rising edge that moves these registers. Each tick is therefore compared with exactly one expected bit: bit k of the expected stream is checked after tick k+1 of the run.

The expected streams are built from the frame rules. They include frames refilled back to back, frames whose pending byte was overwritten, and frames that run under a randomly chosen configuration.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  parameter int DATA_W = 8;
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    MODE_ASYNC = 2'd0,
    MODE_ADDR  = 2'd1,
    MODE_SYNC  = 2'd2,
    MODE_PLAIN = 2'd3
  } txMode_e;

  typedef struct packed {
    txMode_e mode;
    logic    parEn;
    logic    parOdd;
    logic    addrBit;
    logic    framed;
  } txCfg_t;

  typedef struct packed {
    logic load;
    logic shift;
  } txStrobe_t;

  function automatic logic hasFraming(txCfg_t c);
    return !(c.mode == MODE_SYNC && !c.framed);
  endfunction

  function automatic logic hasExtra(txCfg_t c);
    case (c.mode)
      MODE_ASYNC: return c.parEn;
      MODE_ADDR:  return 1'b1;
      MODE_SYNC:  return c.framed && c.parEn;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] frameLen(txCfg_t c);
    logic [CNT_W-1:0] n;
    n = CNT_W'(DATA_W);
    if (hasFraming(c)) n = n + CNT_W'(2);
    if (hasExtra(c)) n = n + CNT_W'(1);
    return n;
  endfunction
endpackage

// File: rtl/sertx_ctrl.sv
module sertx_ctrl
  import sertx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      dataWr,
  input  txCfg_t    cfg,
  output txStrobe_t st,
  output logic      holdEmpty,
  output logic      busy
);
  logic [CNT_W-1:0] bitCnt;
  logic lastBit;

  assign lastBit = busy && (bitCnt == CNT_W'(1));

  always_comb begin
    st.load  = baudTick && !holdEmpty && (!busy || lastBit);
    st.shift = baudTick && busy && !lastBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdEmpty <= 1'b1;
      busy      <= 1'b0;
      bitCnt    <= '0;
    end else begin
      if (dataWr) holdEmpty <= 1'b0;
      else if (st.load) holdEmpty <= 1'b1;

      if (st.load) begin
        busy   <= 1'b1;
        bitCnt <= frameLen(cfg);
      end else if (st.shift) begin
        bitCnt <= bitCnt - CNT_W'(1);
      end else if (baudTick && lastBit) begin
        busy   <= 1'b0;
        bitCnt <= '0;
      end
    end
  end

  // R2
  flag_set_on_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(st.load));
  // R3
  flag_clear_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(holdEmpty) |-> $past(dataWr));
  // R9
  busy_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy != $past(busy)) |-> $past(baudTick));
  // R11
  busy_has_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (bitCnt != '0));
endmodule

// File: rtl/sertx_dp.sv
module sertx_dp
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         st,
  input  txCfg_t            cfg,
  input  logic              busy,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  output logic              txLine
);
  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shReg;

  function automatic logic [FRAME_W-1:0] buildFrame(txCfg_t c, logic [DATA_W-1:0] d);
    logic [FRAME_W-1:0] f;
    logic xb;
    xb = (c.mode == MODE_ADDR) ? c.addrBit : (c.parOdd ? ~^d : ^d);
    f = '1;
    if (!hasFraming(c)) begin
      f[DATA_W-1:0] = d;
    end else begin
      f[0] = 1'b0;
      f[DATA_W:1] = d;
      if (hasExtra(c)) f[DATA_W+1] = xb;
    end
    return f;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg <= '0;
      shReg   <= '1;
    end else begin
      if (dataWr) holdReg <= dataIn;
      if (st.load) shReg <= buildFrame(cfg, holdReg);
      else if (st.shift) shReg <= {1'b1, shReg[FRAME_W-1:1]};
    end
  end

  assign txLine = busy ? shReg[0] : 1'b1;

  // R10
  frame_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!st.load && !st.shift) |=> $stable(shReg));
endmodule

// File: rtl/multimode_tx.sv
module multimode_tx
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              baudTick,
  input  logic              dataWr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [1:0]        txMode,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              addrFlag,
  input  logic              syncFramed,
  input  logic              irqEn,
  output logic              txLine,
  output logic              holdEmpty,
  output logic              txBusy,
  output logic              txIrq
);
  txCfg_t    cfg;
  txStrobe_t st;

  always_comb begin
    cfg.mode    = txMode_e'(txMode);
    cfg.parEn   = parityEn;
    cfg.parOdd  = parityOdd;
    cfg.addrBit = addrFlag;
    cfg.framed  = syncFramed;
  end

  sertx_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .baudTick(baudTick), .dataWr(dataWr),
    .cfg(cfg), .st(st), .holdEmpty(holdEmpty), .busy(txBusy)
  );

  sertx_dp u_dp (
    .clk(clk), .rstN(rstN), .st(st), .cfg(cfg), .busy(txBusy),
    .dataWr(dataWr), .dataIn(dataIn), .txLine(txLine)
  );

  assign txIrq = holdEmpty && irqEn;

  // R11
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);
endmodule

// File: tb/multimode_tx_tb.sv
module multimode_tx_tb;
  logic clk = 0, rstN = 0, baudTick = 0, dataWr = 0;
  logic [7:0] dataIn = 0;
  logic [1:0] txMode = 0;
  logic parityEn = 0, parityOdd = 0, addrFlag = 0, syncFramed = 0, irqEn = 0;
  logic txLine, holdEmpty, txBusy, txIrq;
  int nChk = 0, nBad = 0, cyc = 0;
  logic expBits[0:199];
  logic isStart[0:199];

  multimode_tx u_dut (.*);

  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nBad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChk++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Frame layout from the requirements; returns the frame length
  function automatic int expFrame(input logic [1:0] m, input logic pe, input logic po,
                                  input logic ab, input logic fr, input logic [7:0] d,
                                  output logic [10:0] bits);
    int n;
    logic extra, useExtra;
    bits = '1;
    if (m == 2'd2 && !fr) begin
      bits[7:0] = d;
      return 8;
    end
    useExtra = (m == 2'd0 && pe) || (m == 2'd1) || (m == 2'd2 && pe);
    extra = (m == 2'd1) ? ab : (po ? ~^d : ^d);
    bits[0] = 1'b0;
    for (int i = 0; i < 8; i++) bits[i+1] = d[i];
    n = 9;
    if (useExtra) begin
      bits[n] = extra;
      n++;
    end
    bits[n] = 1'b1;
    return n + 1;
  endfunction

  task automatic doWrite(input logic [7:0] v);
    @(negedge clk); dataWr = 1; dataIn = v;
    @(negedge clk); dataWr = 0;
    chk("R3", "flag after write", holdEmpty, 1'b0);
  endtask

  task automatic doTick();
    @(negedge clk); baudTick = 1;
    @(negedge clk); baudTick = 0;
  endtask

  task automatic setCfg(input logic [1:0] m, input logic pe, input logic po,
                        input logic ab, input logic fr);
    @(negedge clk);
    txMode = m; parityEn = pe; parityOdd = po; addrFlag = ab; syncFramed = fr;
  endtask

  // Send n random bytes back to back, refilled right after each load
  task automatic runStream(input int n, input string req);
    logic [7:0] b[8];
    logic [10:0] fb;
    int total, len, nextByte;
    total = 0;
    for (int i = 0; i < n; i++) begin
      b[i] = 8'($urandom);
      len = expFrame(txMode, parityEn, parityOdd, addrFlag, syncFramed, b[i], fb);
      for (int k = 0; k < len; k++) begin
        expBits[total+k] = fb[k];
        isStart[total+k] = (k == 0);
      end
      total += len;
    end
    doWrite(b[0]);
    nextByte = 1;
    for (int t = 0; t < total; t++) begin
      doTick();
      chk(req, $sformatf("bit %0d", t), txLine, expBits[t]);
      chk("R11", "busy in frame", txBusy, 1'b1);
      if (isStart[t]) begin
        chk("R2", "flag at load", holdEmpty, 1'b1);
        if (nextByte < n) begin
          doWrite(b[nextByte]);
          nextByte++;
        end
      end
    end
    doTick();
    chk("R11", "busy after frame", txBusy, 1'b0);
    chk("R11", "idle line", txLine, 1'b1);
  endtask

  initial begin
    logic [10:0] fB, fD;
    int lenB, lenD;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1", "flag", holdEmpty, 1'b1);
    chk("R1", "busy", txBusy, 1'b0);
    chk("R1", "line", txLine, 1'b1);
    chk("R1", "irq", txIrq, 1'b0);

    // R3, R9: ticks without data start nothing
    repeat (3) doTick();
    chk("R9", "no frame without data", txBusy, 1'b0);
    chk("R3", "flag stays set", holdEmpty, 1'b1);
    chk("R9", "line idle", txLine, 1'b1);

    // R4: interrupt follows flag and enable
    @(negedge clk); irqEn = 1;
    #1 chk("R4", "irq with empty", txIrq, 1'b1);
    doWrite(8'hA5);
    chk("R4", "irq with pending byte", txIrq, 1'b0);
    doTick();
    chk("R4", "irq after load", txIrq, 1'b1);
    repeat (10) doTick();
    @(negedge clk); irqEn = 0;
    #1 chk("R4", "irq disabled", txIrq, 1'b0);

    // R5 mode 0: none, even, odd
    setCfg(2'd0, 0, 0, 0, 0); runStream(3, "R5");
    setCfg(2'd0, 1, 0, 0, 0); runStream(4, "R5");
    setCfg(2'd0, 1, 1, 0, 0); runStream(4, "R5");
    // R6 mode 1, both marker values, parity setting ignored
    setCfg(2'd1, 0, 0, 1, 0); runStream(3, "R6");
    setCfg(2'd1, 1, 1, 0, 0); runStream(3, "R6");
    // R7 mode 2 bare back to back, and framed with parity
    setCfg(2'd2, 1, 0, 0, 0); runStream(5, "R7");
    setCfg(2'd2, 1, 1, 0, 1); runStream(3, "R7");
    // R8 mode 3 ignores parity enable
    setCfg(2'd3, 1, 1, 0, 0); runStream(3, "R8");
    // R9 random configurations
    for (int r = 0; r < 6; r++) begin
      setCfg(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      runStream(1 + int'($urandom % 6), "R9");
    end

    // R10, R12: overwrite pending byte and change config mid-frame
    setCfg(2'd3, 0, 0, 0, 0);
    lenB = expFrame(2'd3, 0, 0, 0, 0, 8'h3C, fB);
    lenD = expFrame(2'd0, 1, 1, 0, 0, 8'h81, fD);
    doWrite(8'h11);
    doWrite(8'h3C);
    for (int t = 0; t < lenB; t++) begin
      doTick();
      chk("R10", $sformatf("overwritten byte bit %0d", t), txLine, fB[t]);
      if (t == 3) begin
        doWrite(8'h77);
        doWrite(8'h81);
        setCfg(2'd0, 1, 1, 0, 0);
      end
    end
    for (int t = 0; t < lenD; t++) begin
      doTick();
      chk("R12", $sformatf("next frame bit %0d", t), txLine, fD[t]);
    end
    doTick();
    chk("R11", "idle after overwrite test", txBusy, 1'b0);

    $display("test done: total=%0d bad=%0d", nChk, nBad);
    $finish;
  end
endmodule